// File: doc/BRIEF.md
# Self-Programming Command Controller

This block sits between a processor core and an on-chip flash array and turns a small command register plus a store-to-program-memory instruction strobe into flash operations. Software writes a five-bit command pattern into the register, which arms a short acceptance window. If the instruction strobe arrives inside that window, the armed command runs. It can load one 16-bit word into a temporary page buffer, erase a page, program a page from the buffer, request a lock-bit update, or request that the read-while-write section be re-enabled. If no strobe comes, the command lapses on its own.

Operations that reach the array use a request/done handshake. The controller captures the target page at the strobe, so the address input is free for other uses afterwards. A busy flag refuses new commands until the array reports completion. When an erase or program targets a page in the upper, no-read-while-write section, the controller stalls the processor for the full duration of the operation.

Top module: `spm_ctrl`

## Requirements
- R1: After reset, ctl_rdata reads 0, busy, cpu_halt and fl_req are low, and every temporary buffer word reads 16'hFFFF.
- R2: When not busy, a command write is accepted only for the patterns 5'b00001 (load), 5'b00011 (erase), 5'b00101 (program), 5'b01001 (lock-set) and 5'b10001 (re-enable). Bit 0 is the enable bit. Any other value leaves ctl_rdata unchanged.
- R3: An accepted pattern stays readable for exactly four clock edges after the write edge. A strobe on any of those four edges is consumed. With no strobe, ctl_rdata reads 0 after the fourth edge, and a later strobe has no effect.
- R4: A strobe consumed under 5'b00001 writes spm_data into buffer word spm_z[5:1], ignores spm_z[0], and clears ctl_rdata.
- R5: A strobe consumed under erase or program produces fl_req for exactly the next cycle. fl_op is 0 for erase and 1 for program, and fl_page is spm_z[12:6]. spm_data is ignored, and fl_page holds that page until completion even if spm_z changes.
- R6: During an erase or program, ctl_rdata keeps the command pattern and busy stays high until fl_done is seen. After that edge, both read 0.
- R7: cpu_halt is high from the cycle after the strobe up to and including the fl_done cycle when the operation is an erase or program and the page is at least NRWW_FIRST (default 96). Otherwise cpu_halt stays low.
- R8: A consumed lock-set or re-enable strobe produces a one-cycle fl_req with fl_op 2 or 3 and fl_page 0, whatever spm_z is. It clears ctl_rdata at once and holds busy high until fl_done, with no halt.
- R9: While busy is high, command writes and strobes are ignored: ctl_rdata, the buffer and fl_req are unaffected.
- R10: Completion of a program operation resets every buffer word to 16'hFFFF. Completion of an erase leaves the buffer as it was.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_we | input | 1 | Command register write strobe |
| ctl_wdata | input | 5 | Command pattern to write |
| ctl_rdata | output | 5 | Current command register contents |
| spm_strobe | input | 1 | Store-to-program-memory instruction strobe |
| spm_z | input | 16 | Address operand: word in bits 5:1, page in bits 12:6 |
| spm_data | input | 16 | Data word for buffer loads |
| buf_rd_idx | input | 5 | Buffer word index for reading |
| buf_rd_data | output | 16 | Buffer word at buf_rd_idx |
| fl_req | output | 1 | One-cycle request to the flash array |
| fl_op | output | 2 | Operation code: 0 erase, 1 program, 2 lock-set, 3 re-enable |
| fl_page | output | 7 | Captured page number |
| fl_done | input | 1 | Completion pulse from the flash array |
| busy | output | 1 | An array operation is pending |
| cpu_halt | output | 1 | Stall request to the processor |

## Verification
The bench places strobes at every offset from zero to five idle edges after arming. A window that is one cycle short drops the strobe on the fourth edge, and one that is one cycle long loads a word that should have lapsed. It writes random five-bit values and compares the register against the five-pattern rule, which catches a decoder that accepts near-misses such as a command bit without the enable bit. Erase and program run on pages 95, 96, 127 and 0 to place the halt boundary exactly. While busy, the bench moves spm_z and issues writes and strobes. A design that re-reads the address, re-arms early or loads the buffer would then show a changed fl_page, ctl_rdata or buffer word.

// File: rtl/spm_ctrl_pkg.sv
package spm_ctrl_pkg;

  typedef enum logic [2:0] {
    K_NONE, K_LOAD, K_ERASE, K_WRITE, K_LOCK, K_RWW
  } spm_kind_e;

  localparam logic [1:0] OP_ERASE = 2'd0;
  localparam logic [1:0] OP_WRITE = 2'd1;
  localparam logic [1:0] OP_LOCK  = 2'd2;
  localparam logic [1:0] OP_RWW   = 2'd3;

  // bit 4 re-enable, bit 3 lock-set, bit 2 program, bit 1 erase, bit 0 enable
  function automatic spm_kind_e decode_cmd(input logic [4:0] v);
    case (v)
      5'b00001: decode_cmd = K_LOAD;
      5'b00011: decode_cmd = K_ERASE;
      5'b00101: decode_cmd = K_WRITE;
      5'b01001: decode_cmd = K_LOCK;
      5'b10001: decode_cmd = K_RWW;
      default:  decode_cmd = K_NONE;
    endcase
  endfunction

endpackage

// File: rtl/spm_cmd_arm.sv
module spm_cmd_arm
  import spm_ctrl_pkg::*;
#(
  parameter int WINDOW = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [4:0] wr_val,
  input  logic       strobe,
  input  logic       busy,
  input  logic       op_done,
  output logic [4:0] ctl_q,
  output spm_kind_e  take_kind
);
  localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic [4:0]    ctl_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          armed, wr_ok, take;
  spm_kind_e     cur_kind;

  assign cur_kind  = decode_cmd(ctl_q);
  assign armed     = ctl_q[0] & ~busy;
  assign wr_ok     = wr_en & ~busy & (decode_cmd(wr_val) != K_NONE);
  assign take      = strobe & armed & ~wr_ok;
  assign take_kind = take ? cur_kind : K_NONE;

  always_comb begin
    ctl_d = ctl_q;
    cnt_d = cnt_q;
    if (op_done) begin
      ctl_d = '0;
    end else if (busy) begin
      ctl_d = ctl_q;
    end else if (wr_ok) begin
      ctl_d = wr_val;
      cnt_d = CW'(WINDOW - 1);
    end else if (armed) begin
      if (take) begin
        if (cur_kind != K_ERASE && cur_kind != K_WRITE) ctl_d = '0;
      end else if (cnt_q == '0) begin
        ctl_d = '0;
      end else begin
        cnt_d = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      cnt_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      cnt_q <= cnt_d;
    end
  end

  p_legal_ctl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q == '0) || (decode_cmd(ctl_q) != K_NONE));

  p_window_expire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !strobe && !wr_en && cnt_q == '0) |=> (ctl_q == '0));

  p_hold_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !op_done) |=> $stable(ctl_q));

endmodule

// File: rtl/spm_page_buf.sv
module spm_page_buf #(
  parameter int WORDS = 32,
  parameter int DW    = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     ld_en,
  input  logic [$clog2(WORDS)-1:0] ld_idx,
  input  logic [DW-1:0]            ld_data,
  input  logic                     fill_ones,
  input  logic [$clog2(WORDS)-1:0] rd_idx,
  output logic [DW-1:0]            rd_data
);
  localparam int IW = $clog2(WORDS);

  logic [DW-1:0] mem_q [WORDS];

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    logic          wen;
    logic [DW-1:0] word_d;
    assign wen = fill_ones | (ld_en & (ld_idx == IW'(i)));
    always_comb begin
      word_d = fill_ones ? '1 : ld_data;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   mem_q[i] <= '1;
      else if (wen) mem_q[i] <= word_d;
    end
  end

  assign rd_data = mem_q[rd_idx];

  p_no_load_on_fill_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_ones |-> !ld_en);

endmodule

// File: rtl/spm_flash_seq.sv
module spm_flash_seq
  import spm_ctrl_pkg::*;
#(
  parameter int PAGES      = 128,
  parameter int NRWW_FIRST = 96
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  spm_kind_e                kind,
  input  logic [$clog2(PAGES)-1:0] page_in,
  input  logic                     fl_done,
  output logic                     fl_req,
  output logic [1:0]               fl_op,
  output logic [$clog2(PAGES)-1:0] fl_page,
  output logic                     busy,
  output logic                     halt,
  output logic                     op_done,
  output logic                     write_done
);
  localparam int PW = $clog2(PAGES);

  logic          pend_q, pend_d;
  logic          req_q, req_d;
  logic          halt_q, halt_d;
  logic [1:0]    op_q, op_d;
  logic [PW-1:0] page_q, page_d;
  logic          launch, page_op;

  assign page_op = (kind == K_ERASE) || (kind == K_WRITE);
  assign launch  = page_op || (kind == K_LOCK) || (kind == K_RWW);
  assign op_done = pend_q & fl_done;

  always_comb begin
    pend_d = pend_q;
    halt_d = halt_q;
    op_d   = op_q;
    page_d = page_q;
    req_d  = 1'b0;
    if (launch) begin
      pend_d = 1'b1;
      req_d  = 1'b1;
      page_d = page_op ? page_in : '0;
      halt_d = page_op && (page_in >= PW'(NRWW_FIRST));
      case (kind)
        K_ERASE: op_d = OP_ERASE;
        K_WRITE: op_d = OP_WRITE;
        K_LOCK:  op_d = OP_LOCK;
        default: op_d = OP_RWW;
      endcase
    end else if (op_done) begin
      pend_d = 1'b0;
      halt_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      req_q  <= 1'b0;
      halt_q <= 1'b0;
      op_q   <= OP_ERASE;
      page_q <= '0;
    end else begin
      pend_q <= pend_d;
      req_q  <= req_d;
      halt_q <= halt_d;
      op_q   <= op_d;
      page_q <= page_d;
    end
  end

  assign fl_req     = req_q;
  assign fl_op      = op_q;
  assign fl_page    = page_q;
  assign busy       = pend_q;
  assign halt       = halt_q & pend_q;
  assign write_done = op_done & (op_q == OP_WRITE);

  p_req_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fl_req |=> !fl_req);

  p_page_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && !launch) |=> $stable(page_q));

  p_halt_only_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    halt |-> (busy && page_q >= PW'(NRWW_FIRST) && op_q <= OP_WRITE));

  p_no_launch_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> !launch);

endmodule

// File: rtl/spm_ctrl.sv
module spm_ctrl
  import spm_ctrl_pkg::*;
#(
  parameter int WORDS      = 32,
  parameter int PAGES      = 128,
  parameter int NRWW_FIRST = 96,
  parameter int WINDOW     = 4,
  parameter int DW         = 16,
  parameter int AW         = 16,
  parameter int IW         = $clog2(WORDS),
  parameter int PW         = $clog2(PAGES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ctl_we,
  input  logic [4:0]    ctl_wdata,
  output logic [4:0]    ctl_rdata,
  input  logic          spm_strobe,
  input  logic [AW-1:0] spm_z,
  input  logic [DW-1:0] spm_data,
  input  logic [IW-1:0] buf_rd_idx,
  output logic [DW-1:0] buf_rd_data,
  output logic          fl_req,
  output logic [1:0]    fl_op,
  output logic [PW-1:0] fl_page,
  input  logic          fl_done,
  output logic          busy,
  output logic          cpu_halt
);
  spm_kind_e     take_kind;
  logic          op_done, write_done;
  logic [IW-1:0] word_idx;
  logic [PW-1:0] page_idx;
  logic          unused_z;

  assign word_idx = spm_z[1 +: IW];
  assign page_idx = spm_z[IW+1 +: PW];
  assign unused_z = ^spm_z;

  spm_cmd_arm #(.WINDOW(WINDOW)) u_arm (
    .clk(clk), .rst_n(rst_n),
    .wr_en(ctl_we), .wr_val(ctl_wdata),
    .strobe(spm_strobe), .busy(busy), .op_done(op_done),
    .ctl_q(ctl_rdata), .take_kind(take_kind)
  );

  spm_page_buf #(.WORDS(WORDS), .DW(DW)) u_buf (
    .clk(clk), .rst_n(rst_n),
    .ld_en(take_kind == K_LOAD), .ld_idx(word_idx), .ld_data(spm_data),
    .fill_ones(write_done),
    .rd_idx(buf_rd_idx), .rd_data(buf_rd_data)
  );

  spm_flash_seq #(.PAGES(PAGES), .NRWW_FIRST(NRWW_FIRST)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .kind(take_kind), .page_in(page_idx), .fl_done(fl_done),
    .fl_req(fl_req), .fl_op(fl_op), .fl_page(fl_page),
    .busy(busy), .halt(cpu_halt),
    .op_done(op_done), .write_done(write_done)
  );

endmodule

// File: tb/spm_ctrl_test.sv
`timescale 1ns/1ps
module spm_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NRWW = 96;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        ctl_we;
  logic [4:0]  ctl_wdata;
  logic [4:0]  ctl_rdata;
  logic        spm_strobe;
  logic [15:0] spm_z, spm_data;
  logic [4:0]  buf_rd_idx;
  logic [15:0] buf_rd_data;
  logic        fl_req, fl_done, busy, cpu_halt;
  logic [1:0]  fl_op;
  logic [6:0]  fl_page;

  int n_chk = 0, n_bad = 0;
  bit done_flag = 0;
  logic [15:0] model [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  spm_ctrl uut (
    .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .ctl_rdata(ctl_rdata), .spm_strobe(spm_strobe), .spm_z(spm_z),
    .spm_data(spm_data), .buf_rd_idx(buf_rd_idx), .buf_rd_data(buf_rd_data),
    .fl_req(fl_req), .fl_op(fl_op), .fl_page(fl_page), .fl_done(fl_done),
    .busy(busy), .cpu_halt(cpu_halt)
  );

  function automatic bit legal(input logic [4:0] v);
    return v == 5'b00001 || v == 5'b00011 || v == 5'b00101 ||
           v == 5'b01001 || v == 5'b10001;
  endfunction

  function automatic logic [15:0] mkz(input int page, input int word, input bit lsb);
    return 16'((page << 6) | (word << 1) | lsb) | 16'(($urandom & 7) << 13);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [4:0] v);
    ctl_we = 1'b1; ctl_wdata = v;
    step();
    ctl_we = 1'b0;
  endtask

  task automatic strobe(input logic [15:0] z, input logic [15:0] d);
    spm_strobe = 1'b1; spm_z = z; spm_data = d;
    step();
    spm_strobe = 1'b0;
  endtask

  task automatic check_buf(input string tag);
    bit ok = 1;
    for (int i = 0; i < 32; i++) begin
      buf_rd_idx = 5'(i);
      #1;
      if (buf_rd_data !== model[i]) begin
        ok = 0;
        check(0, tag, buf_rd_data, model[i]);
      end
    end
    if (ok) check(1, tag, 0, 0);
  endtask

  task automatic page_op(input logic [4:0] pat, input int page, input int dly);
    logic [1:0] exp_op;
    bit pg, exp_halt;
    logic [6:0] exp_page;
    pg = (pat == 5'b00011) || (pat == 5'b00101);
    exp_op = pat == 5'b00011 ? 2'd0 : pat == 5'b00101 ? 2'd1 : pat == 5'b01001 ? 2'd2 : 2'd3;
    exp_page = pg ? 7'(page) : 7'd0;
    exp_halt = pg && page >= NRWW;
    wr_ctl(pat);
    strobe(mkz(page, $urandom % 32, 1'($urandom)), 16'($urandom));
    check(fl_req === 1'b1, "R5/R8 fl_req pulse", fl_req, 1);
    check(fl_op === exp_op, "R5/R8 fl_op", fl_op, exp_op);
    check(fl_page === exp_page, "R5/R8 fl_page", fl_page, exp_page);
    check(busy === 1'b1, "R6/R8 busy", busy, 1);
    check(cpu_halt === exp_halt, "R7 halt start", cpu_halt, exp_halt);
    check(ctl_rdata === (pg ? pat : 5'd0), "R6/R8 ctl during op", ctl_rdata, pg ? pat : 5'd0);
    spm_z = 16'($urandom);
    wr_ctl(5'b00001);                                   // R9 ignored while busy
    check(ctl_rdata === (pg ? pat : 5'd0), "R9 write while busy", ctl_rdata, pg ? pat : 5'd0);
    check(fl_req === 1'b0, "R5 fl_req one cycle", fl_req, 0);
    strobe(16'($urandom), 16'h1234);                    // R9 strobe ignored
    check(fl_page === exp_page, "R5 page held", fl_page, exp_page);
    check(fl_req === 1'b0, "R9 no request on busy strobe", fl_req, 0);
    for (int i = 0; i < dly; i++) begin
      step();
      check(cpu_halt === exp_halt && busy === 1'b1, "R7 halt held", cpu_halt, exp_halt);
    end
    fl_done = 1'b1;
    #1;
    check(cpu_halt === exp_halt, "R7 halt in done cycle", cpu_halt, exp_halt);
    step();
    fl_done = 1'b0;
    check(busy === 1'b0 && ctl_rdata === 5'd0, "R6 clear after done", {busy, ctl_rdata}, 0);
    check(cpu_halt === 1'b0, "R7 halt released", cpu_halt, 0);
    if (pat == 5'b00101) for (int i = 0; i < 32; i++) model[i] = 16'hFFFF;
    check_buf(pat == 5'b00101 ? "R10 program fills ones" : "R10 buffer kept / R9");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    rst_n = 1'b0; ctl_we = 0; ctl_wdata = 0; spm_strobe = 0;
    spm_z = 0; spm_data = 0; fl_done = 0; buf_rd_idx = 0;
    for (int i = 0; i < 32; i++) model[i] = 16'hFFFF;
    repeat (3) step();
    rst_n = 1'b1;
    step();

    // R1 reset state
    check(ctl_rdata === 5'd0, "R1 ctl reset", ctl_rdata, 0);
    check({busy, cpu_halt, fl_req} === 3'b000, "R1 flags reset", {busy, cpu_halt, fl_req}, 0);
    check_buf("R1 buffer ones");

    // R2 / R3: random patterns, exact window length
    for (int it = 0; it < 40; it++) begin
      logic [4:0] v;
      v = (it < 5) ? (it == 0 ? 5'b00001 : it == 1 ? 5'b00011 : it == 2 ? 5'b00101 :
                      it == 3 ? 5'b01001 : 5'b10001) : 5'($urandom);
      wr_ctl(v);
      check(ctl_rdata === (legal(v) ? v : 5'd0), "R2 pattern filter", ctl_rdata, legal(v) ? v : 5'd0);
      repeat (3) step();
      check(ctl_rdata === (legal(v) ? v : 5'd0), "R3 still armed at edge 3", ctl_rdata, legal(v) ? v : 5'd0);
      step();
      check(ctl_rdata === 5'd0, "R3 expired at edge 4", ctl_rdata, 0);
    end

    // R3 / R4: strobe after k idle edges
    for (int k = 0; k < 6; k++) begin
      logic [15:0] d;
      d = 16'hA000 + 16'(k);
      wr_ctl(5'b00001);
      repeat (k) step();
      strobe(mkz($urandom % 128, k + 8, k[0]), d);
      if (k <= 3) model[k + 8] = d;
      check(ctl_rdata === 5'd0, "R4 ctl clears after load", ctl_rdata, 0);
      buf_rd_idx = 5'(k + 8);
      #1;
      check(buf_rd_data === model[k + 8], "R3 window edge load", buf_rd_data, model[k + 8]);
    end

    // R4 random buffer fills
    for (int it = 0; it < 24; it++) begin
      int w;
      logic [15:0] d;
      w = $urandom % 32;
      d = 16'($urandom);
      wr_ctl(5'b00001);
      repeat ($urandom % 4) step();
      strobe(mkz($urandom % 128, w, 1'($urandom)), d);
      model[w] = d;
    end
    check_buf("R4 random fill");

    // strobe with nothing armed is ignored
    strobe(mkz(3, 4, 0), 16'h0BAD);
    check_buf("R9 unarmed strobe ignored");

    // R5-R10 array operations across the halt boundary
    page_op(5'b00011, NRWW, 3);
    page_op(5'b00101, NRWW - 1, 2);
    wr_ctl(5'b00001); strobe(mkz(0, 7, 0), 16'h5555); model[7] = 16'h5555;
    page_op(5'b00011, 0, 1);
    page_op(5'b00101, 127, 4);
    page_op(5'b01001, 120, 2);
    page_op(5'b10001, 100, 0);
    for (int it = 0; it < 6; it++) begin
      page_op(($urandom & 1) ? 5'b00011 : 5'b00101, $urandom % 128, $urandom % 5);
    end

    done_flag = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule